// File: doc/BRIEF.md
# Locked Atomic Read-Modify-Write Sequencer

This block sits between a requester and a single memory port and carries out an indivisible read-modify-write on one memory word. A request names one of four operations, a word address, a register operand and a bit index. The sequencer reads the word, computes the replacement value, writes it back and then reports the word as it was before the write, together with a carry flag. A lock output is held high from the read through the acknowledged write, so that a bus fabric can keep other agents away from that word.

The operations are an exchange (the operand replaces the memory word and the old word goes back to the requester) and three single-bit operations: test-and-set, test-and-clear and test-and-invert. Each bit operation returns the bit's prior value as the carry flag. The sequencer handles one operation at a time. It waits as long as the memory takes to return read data and to acknowledge the write.

Top module: `atomic_rmw_unit`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A `req_valid` pulse while `req_ready` is low is ignored: it changes neither the memory write nor the response.
- R2: Opcode 0 (exchange) writes `req_operand` to memory, returns the old word on `rsp_old` and returns `rsp_flag` = 0.
- R3: Opcode 1 (test-and-set) returns the selected bit of the old word on `rsp_flag` and writes the old word with that bit forced to 1. All other bits are unchanged.
- R4: Opcode 2 (test-and-clear) returns the selected bit on `rsp_flag` and writes the old word with that bit forced to 0. All other bits are unchanged.
- R5: Opcode 3 (test-and-invert) returns the selected bit on `rsp_flag` and writes the old word with that bit inverted. All other bits are unchanged.
- R6: The selected bit is `req_bit` modulo the data width (32). Index 37 selects bit 5.
- R7: `mem_lock` rises in the cycle after acceptance. It stays high through the read and the write with no gap, and falls in the cycle after the write acknowledge.
- R8: `mem_rd_en` and `mem_addr` are held from the cycle after acceptance until a cycle with `mem_rd_valid`. The write starts in the next cycle. `mem_wr_en`, `mem_addr` and `mem_wdata` are held until a cycle with `mem_wr_ack`.
- R9: `rsp_valid` is high for exactly one cycle, the cycle after the write acknowledge, with `mem_lock` low. `req_ready` returns in the next cycle.
- R10: While reset is high and directly after it, `req_ready` = 1 and `mem_lock`, `mem_rd_en`, `mem_wr_en` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | 0 exchange, 1 test-and-set, 2 test-and-clear, 3 test-and-invert |
| req_addr | input | ADDR_W (8) | Word address |
| req_operand | input | DATA_W (32) | Register operand for exchange |
| req_bit | input | IDX_W (8) | Bit index, taken modulo DATA_W |
| mem_lock | output | 1 | Bus lock for the whole sequence |
| mem_rd_en | output | 1 | Read request |
| mem_wr_en | output | 1 | Write request |
| mem_addr | output | ADDR_W (8) | Memory word address |
| mem_wdata | output | DATA_W (32) | Write data |
| mem_rdata | input | DATA_W (32) | Read data, sampled with mem_rd_valid |
| mem_rd_valid | input | 1 | Read data valid |
| mem_wr_ack | input | 1 | Write accepted |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_old | output | DATA_W (32) | Memory word before the write |
| rsp_flag | output | 1 | Prior value of the selected bit |

## Verification
The assertions assume that the memory raises `mem_rd_valid` only while a read is pending and `mem_wr_ack` only while a write is pending. They also assume that the memory answers each request within finite time. The bench's memory model obeys this: it drives each strobe for a single cycle, only in the last cycle of a read or write phase, with a latency set for each operation from 0 to 3 extra cycles. Requests arriving while the block is busy are allowed by the assertions. The bench raises them on purpose, with garbage fields, to show that they are ignored.

// File: rtl/armw_pkg.sv
package armw_pkg;

    typedef enum logic [1:0] {
        OP_XCHG = 2'd0,
        OP_BTS  = 2'd1,
        OP_BTR  = 2'd2,
        OP_BTC  = 2'd3
    } rmw_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic ready;
        logic lock;
        logic rd_en;
        logic wr_en;
        logic rsp_valid;
    } seq_ctrl_t;

    // New value of the addressed bit for a single-bit operation.
    function automatic logic bit_update(input rmw_op_e op, input logic cur);
        case (op)
            OP_BTS:  return 1'b1;
            OP_BTR:  return 1'b0;
            OP_BTC:  return ~cur;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/armw_seq.sv
module armw_seq
    import armw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      rd_valid,
    input  logic      wr_ack,
    output seq_ctrl_t ctrl,
    output logic      rd_done
);

    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (start)    state_d = ST_READ;
            ST_READ:  if (rd_valid) state_d = ST_WRITE;
            ST_WRITE: if (wr_ack)   state_d = ST_DONE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        ctrl           = '0;
        ctrl.ready     = (state_q == ST_IDLE);
        ctrl.lock      = (state_q == ST_READ) || (state_q == ST_WRITE);
        ctrl.rd_en     = (state_q == ST_READ);
        ctrl.wr_en     = (state_q == ST_WRITE);
        ctrl.rsp_valid = (state_q == ST_DONE);
    end

    assign rd_done = (state_q == ST_READ) && rd_valid;

endmodule

// File: rtl/armw_modify.sv
module armw_modify
    import armw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input  rmw_op_e             op,
    input  logic [DATA_W-1:0]   old_word,
    input  logic [DATA_W-1:0]   operand,
    input  logic [IDX_W-1:0]    bit_idx,
    output logic [DATA_W-1:0]   new_word,
    output logic                flag
);

    // DATA_W is a power of two, so modulo is a mask.
    localparam logic [IDX_W-1:0] IDX_MASK = IDX_W'(DATA_W - 1);

    logic [IDX_W-1:0]  idx_red;
    logic [DATA_W-1:0] sel;

    assign idx_red = bit_idx & IDX_MASK;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign sel[i] = (idx_red == IDX_W'(i));
        always_comb begin
            if (op == OP_XCHG)
                new_word[i] = operand[i];
            else if (sel[i])
                new_word[i] = bit_update(op, old_word[i]);
            else
                new_word[i] = old_word[i];
        end
    end

    assign flag = (op != OP_XCHG) && |(old_word & sel);

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import armw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_operand,
    input  logic [IDX_W-1:0]  req_bit,
    output logic              mem_lock,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rd_valid,
    input  logic              mem_wr_ack,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_old,
    output logic              rsp_flag
);

    seq_ctrl_t         ctrl;
    logic              accept;
    logic              rd_done;
    rmw_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] operand_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] old_q;
    logic [DATA_W-1:0] new_word;
    logic              flag;

    assign accept = req_valid && ctrl.ready;

    armw_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .rd_valid (mem_rd_valid),
        .wr_ack   (mem_wr_ack),
        .ctrl     (ctrl),
        .rd_done  (rd_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q      <= OP_XCHG;
            addr_q    <= '0;
            operand_q <= '0;
            idx_q     <= '0;
        end else if (accept) begin
            op_q      <= rmw_op_e'(req_op);
            addr_q    <= req_addr;
            operand_q <= req_operand;
            idx_q     <= req_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          old_q <= '0;
        else if (rd_done) old_q <= mem_rdata;
    end

    armw_modify #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_modify (
        .op       (op_q),
        .old_word (old_q),
        .operand  (operand_q),
        .bit_idx  (idx_q),
        .new_word (new_word),
        .flag     (flag)
    );

    assign req_ready = ctrl.ready;
    assign mem_lock  = ctrl.lock;
    assign mem_rd_en = ctrl.rd_en;
    assign mem_wr_en = ctrl.wr_en;
    assign mem_addr  = addr_q;
    assign mem_wdata = new_word;
    assign rsp_valid = ctrl.rsp_valid;
    assign rsp_old   = old_q;
    assign rsp_flag  = ctrl.rsp_valid && flag;

    AST_ACCEPT_LOCKS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (mem_lock && mem_rd_en && !req_ready)); // R7

    AST_READ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && !mem_rd_valid) |=> (mem_rd_en && mem_lock && $stable(mem_addr))); // R8

    AST_READ_TO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && mem_rd_valid) |=> (mem_wr_en && mem_lock && !mem_rd_en)); // R8

    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && !mem_wr_ack) |=> (mem_wr_en && mem_lock && $stable(mem_wdata) && $stable(mem_addr))); // R8

    AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && mem_wr_ack) |=> (!mem_lock && rsp_valid)); // R7

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready && !mem_lock)); // R9

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (mem_lock || rsp_valid) |-> !req_ready); // R1

    AST_SINGLE_BIT_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && op_q != OP_XCHG) |-> ($countones(mem_wdata ^ rsp_old) <= 1)); // R3

    AST_XCHG_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && op_q == OP_XCHG) |-> !rsp_flag); // R2

endmodule

// File: tb/test_atomic_rmw_unit.sv
`timescale 1ns/1ps
module test_atomic_rmw_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [1:0]  req_op;
    logic [7:0]  req_addr;
    logic [31:0] req_operand;
    logic [7:0]  req_bit;
    logic        mem_lock, mem_rd_en, mem_wr_en;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_rd_valid, mem_wr_ack;
    logic        rsp_valid;
    logic [31:0] rsp_old;
    logic        rsp_flag;

    logic [31:0] mem_model [16];
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    atomic_rmw_unit i_atomic_rmw_unit (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_operand(req_operand), .req_bit(req_bit),
        .mem_lock(mem_lock), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rd_valid(mem_rd_valid), .mem_wr_ack(mem_wr_ack),
        .rsp_valid(rsp_valid), .rsp_old(rsp_old), .rsp_flag(rsp_flag)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Pattern order: {lock, rd_en, wr_en, ready, rsp_valid}
    task automatic check_ctrl(string req, logic [4:0] exp);
        check(req, "ctrl", {27'd0, mem_lock, mem_rd_en, mem_wr_en, req_ready, rsp_valid},
              {27'd0, exp});
    endtask

    task automatic do_op(int op, int addr, logic [31:0] operand, int idx,
                         int rd_lat, int wr_lat, bit noise, string req);
        logic [31:0] old_w, new_w;
        logic        flg;
        int          b;
        b     = idx % 32;
        old_w = mem_model[addr];
        flg   = 1'b0;
        case (op)
            0: new_w = operand;
            1: begin flg = old_w[b]; new_w = old_w | (32'h1 << b);    end
            2: begin flg = old_w[b]; new_w = old_w & ~(32'h1 << b);   end
            default: begin flg = old_w[b]; new_w = old_w ^ (32'h1 << b); end
        endcase

        check_ctrl("R1", 5'b00010);
        req_valid   = 1'b1;
        req_op      = 2'(op);
        req_addr    = 8'(addr);
        req_operand = operand;
        req_bit     = 8'(idx);
        @(posedge clk); @(negedge clk);
        if (noise) begin
            req_op      = ~req_op;
            req_addr    = req_addr ^ 8'h0F;
            req_operand = ~operand;
            req_bit     = req_bit + 8'd3;
        end else begin
            req_valid = 1'b0;
        end

        for (int k = 0; k <= rd_lat; k++) begin
            check_ctrl("R7", 5'b11000);
            check("R8", "read addr", {24'd0, mem_addr}, 32'(addr));
            if (k == rd_lat) begin
                mem_rd_valid = 1'b1;
                mem_rdata    = old_w;
            end else begin
                mem_rdata    = 32'h0BAD_F00D;
            end
            @(posedge clk); @(negedge clk);
            mem_rd_valid = 1'b0;
        end

        for (int k = 0; k <= wr_lat; k++) begin
            check_ctrl("R8", 5'b10100);
            check("R8", "write addr", {24'd0, mem_addr}, 32'(addr));
            check(req, "wdata", mem_wdata, new_w);
            if (k == wr_lat) mem_wr_ack = 1'b1;
            @(posedge clk); @(negedge clk);
            mem_wr_ack = 1'b0;
        end
        mem_model[addr] = new_w;

        check_ctrl("R9", 5'b00001);
        check(req, "rsp_old", rsp_old, old_w);
        check(req, "rsp_flag", {31'd0, rsp_flag}, {31'd0, flg});
        req_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        check_ctrl("R9", 5'b00010);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem_model[i] = 32'h1357_9BDF ^ (32'h0101_0101 * i);
        rst = 1'b1;
        req_valid = 1'b0; req_op = 2'd0; req_addr = '0; req_operand = '0; req_bit = '0;
        mem_rdata = '0; mem_rd_valid = 1'b0; mem_wr_ack = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_ctrl("R10", 5'b00010);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check_ctrl("R10", 5'b00010);

        do_op(0, 3, 32'hDEAD_BEEF, 0, 0, 0, 1'b0, "R2");
        do_op(0, 3, 32'h0000_0042, 9, 1, 2, 1'b0, "R2");
        mem_model[5] = 32'h0000_0000;
        do_op(0, 5, 32'h0000_0000, 0, 0, 0, 1'b0, "R2");
        do_op(1, 5, 32'h0, 4, 0, 0, 1'b0, "R3");
        do_op(1, 5, 32'h0, 4, 2, 0, 1'b0, "R3");
        do_op(1, 7, 32'h0, 31, 0, 3, 1'b0, "R3");
        do_op(2, 7, 32'h0, 31, 2, 1, 1'b0, "R4");
        do_op(2, 7, 32'h0, 31, 0, 0, 1'b0, "R4");
        do_op(2, 9, 32'h0, 0, 1, 1, 1'b0, "R4");
        do_op(3, 11, 32'h0, 37, 0, 0, 1'b0, "R6");
        do_op(3, 11, 32'h0, 37, 1, 0, 1'b0, "R6");
        do_op(3, 12, 32'h0, 18, 3, 2, 1'b0, "R5");
        do_op(1, 12, 32'h0, 255, 0, 1, 1'b0, "R6");
        do_op(0, 2, 32'hCAFE_F00D, 0, 3, 3, 1'b1, "R1");
        do_op(3, 2, 32'h0, 6, 2, 2, 1'b1, "R1");
        do_op(0, 2, 32'h1234_5678, 0, 0, 0, 1'b0, "R2");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule